// File: doc/BRIEF.md
# T1 Receive Timing Pulse Generator

This block sits behind a T1 receive framer. The framer has already found frame alignment. From the receive bit clock and a frame-start indication, the block keeps one bit-position counter and one frame-in-multiframe counter. It decodes every timing strobe that downstream serial logic needs from those two counters.

Each 193-bit frame starts with one framing bit, followed by 24 channels of 8 bits each, most significant bit first. The block produces four outputs:

- a frame sync pulse;
- a multiframe sync pulse;
- a shared clock output (`aux_clk`);
- a shared data output (`aux_dat`).

A select input decides what the shared pair carries. With the select low, it carries a channel clock and a per-channel block strobe driven from a 24-bit user mask. With the select high, it carries a link clock and link data taken from the framing bits. A two-bit format input chooses among three framing formats: 12-frame superframe, 24-frame extended superframe, and the 24-frame zero-byte time-slot-interchange variant. The format fixes the multiframe length, the signalling frames and which framing bits form the link.

The receive data input leads the block's outputs by two bit periods. Because of this, the framing bit of an upcoming frame can be shown on the link data output one bit time before that frame begins.

Top module: `t1_rx_timing`

## Requirements
- R1: Bit position 0 of each 193-bit frame is the framing bit. A `frame_start` pulse in any cycle makes the next cycle position 0. With `mf_start` also high, that next frame is frame 1 of the multiframe; otherwise the frame number advances by one. Without `frame_start`, the counters wrap on their own after position 192.
- R2: With `link_sel` low, `aux_clk` is high exactly at positions 8, 16, …, 192. These are the least significant bits of channels 1 to 24.
- R3: With `link_sel` low, `aux_dat` is high for all 8 bits of channel k (positions 8k-7 to 8k) when `chan_mask` bit k-1 is set. It is low for the other channels and during the framing bit.
- R4: `frame_sync` is high for one clock at position 0. When `dbl_sig_en` is set, it also stays high at position 1 in signalling frames. Signalling frames are 6 and 12 in the superframe format, and 6, 12, 18 and 24 in the 24-frame formats.
- R5: `mframe_sync` is high for one clock, at position 0 of frame 1. A multiframe is 12 frames for `fmt` = 00 and 24 frames for `fmt` = 01, 10 and 11.
- R6: With `link_sel` high, `aux_clk` is high at position 0 of each link frame. Link frames are the even-numbered frames for `fmt` = 00, frames 1, 5, 9, 13, 17 and 21 for `fmt` = 10, and the odd-numbered frames for `fmt` = 01 and 11. This gives 4 kHz, 2 kHz and 4 kHz link clocks.
- R7: With `link_sel` high, `aux_dat` shows the framing bit of each link frame from position 192 of the frame before it. It holds that value until the next update. During position p, `rx_data` carries the bit of position p+2 (mod 193).
- R8: `link_sel` low selects the channel clock and channel block onto `aux_clk`/`aux_dat`. `link_sel` high selects the link clock and link data.
- R9: All four outputs are low whenever `aligned` is low. After `aligned` rises, they stay low until the cycle after a `frame_start`.
- R10: During reset and directly after it, all four outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive bit clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| fmt | input | 2 | Framing format: 00 superframe, 01 extended, 10 zero-byte variant, 11 as 01 |
| link_sel | input | 1 | Shared pair select: 0 channel clock/block, 1 link clock/data |
| dbl_sig_en | input | 1 | Double-wide frame sync on signalling frames |
| chan_mask | input | 24 | Per-channel block mask, bit 0 = channel 1 |
| aligned | input | 1 | Frame alignment held by the upstream framer |
| frame_start | input | 1 | Next cycle is a framing bit |
| mf_start | input | 1 | With frame_start: next frame is frame 1 |
| rx_data | input | 1 | Receive serial data, two bit periods ahead of the outputs |
| frame_sync | output | 1 | Frame boundary pulse |
| mframe_sync | output | 1 | Multiframe boundary pulse |
| aux_clk | output | 1 | Channel clock or link clock |
| aux_dat | output | 1 | Channel block or link data |

## Verification
The bench builds the block with its default parameters: a 193-bit frame of 24 channels of 8 bits. The signalling frame numbers, link frame numbers and multiframe lengths are defined for that shape.

These defaults cover:
- every bit of the full 24-bit mask;
- the frame counter wrapping from frame 24 back to frame 1, and from frame 12 in the superframe format;
- all four format codes, including the reserved one.

They also allow the realignment cases to be reached at an arbitrary bit position, with the link data update taken at the 192nd position.

// File: rtl/t1rt_pkg.sv
`timescale 1ns/1ps
// t1rt_pkg: shared types and frame-number decoders for the T1 receive timing block.
// Assumes frame numbers are kept zero-based (0 = frame 1 of the multiframe).
package t1rt_pkg;

    typedef enum logic [1:0] {
        FMT_SF  = 2'b00,
        FMT_ESF = 2'b01,
        FMT_ZB  = 2'b10,
        FMT_RSV = 2'b11
    } fmt_e;

    localparam int MF_SHORT    = 12;
    localparam int MF_LONG     = 24;
    localparam int SIG_SPACING = 6;
    localparam int FRM_W       = $clog2(MF_LONG);

    // Last zero-based frame index of the multiframe for a format.
    function automatic logic [FRM_W-1:0] mf_last(fmt_e f);
        return (f == FMT_SF) ? FRM_W'(MF_SHORT - 1) : FRM_W'(MF_LONG - 1);
    endfunction

    // Signalling frame: every sixth frame (frame numbers 6, 12, 18, 24).
    function automatic logic sig_frame(logic [FRM_W-1:0] n);
        return (n % FRM_W'(SIG_SPACING)) == FRM_W'(SIG_SPACING - 1);
    endfunction

    // Frame whose framing bit belongs to the link for a format.
    function automatic logic link_frame(fmt_e f, logic [FRM_W-1:0] n);
        if (f == FMT_SF)
            return n[0];
        else if (f == FMT_ZB)
            return n[1:0] == 2'b00;
        else
            return !n[0];
    endfunction

endpackage

// File: rtl/t1rt_count.sv
`timescale 1ns/1ps
// t1rt_count: bit-position, channel, slot and frame counters plus the run flag.
// Assumes frame_start marks the last bit before a framing bit; the counters
// free-run between frame_start pulses and reload on each one.
module t1rt_count
    import t1rt_pkg::*;
#(
    parameter int CHANNELS = 24,
    parameter int CH_BITS  = 8,
    localparam int FRAME_BITS = 1 + CHANNELS * CH_BITS,
    localparam int POS_W  = $clog2(FRAME_BITS),
    localparam int CH_W   = $clog2(CHANNELS),
    localparam int SLOT_W = $clog2(CH_BITS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  fmt_e              fmt,
    input  logic              aligned,
    input  logic              frame_start,
    input  logic              mf_start,
    output logic [POS_W-1:0]  pos,
    output logic [CH_W-1:0]   chan,
    output logic [SLOT_W-1:0] slot,
    output logic [FRM_W-1:0]  frm,
    output logic [FRM_W-1:0]  nxt_frm,
    output logic              run
);
    localparam logic [POS_W-1:0]  POS_LAST  = POS_W'(FRAME_BITS - 1);
    localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(CH_BITS - 1);

    logic wrap;

    // Next frame index with multiframe wrap for the selected format.
    always_comb begin
        wrap    = frame_start || (pos == POS_LAST);
        nxt_frm = (frm >= mf_last(fmt)) ? '0 : frm + 1'b1;
    end

    // Bit position within the frame.
    always_ff @(posedge clk) begin
        if (!rst_n)    pos <= '0;
        else if (wrap) pos <= '0;
        else           pos <= pos + 1'b1;
    end

    // Channel number and bit slot inside the channel (valid when pos != 0).
    always_ff @(posedge clk) begin
        if (!rst_n || wrap) begin
            chan <= '0;
            slot <= '0;
        end else if (pos != '0) begin
            if (slot == SLOT_LAST) begin
                slot <= '0;
                chan <= chan + 1'b1;
            end else begin
                slot <= slot + 1'b1;
            end
        end
    end

    // Frame number within the multiframe.
    always_ff @(posedge clk) begin
        if (!rst_n)                       frm <= '0;
        else if (frame_start && mf_start) frm <= '0;
        else if (wrap)                    frm <= nxt_frm;
    end

    // Outputs run only after a frame_start seen while aligned.
    always_ff @(posedge clk) begin
        if (!rst_n || !aligned) run <= 1'b0;
        else if (frame_start)   run <= 1'b1;
    end

endmodule

// File: rtl/t1rt_link.sv
`timescale 1ns/1ps
// t1rt_link: captures the next link frame's framing bit from the leading
// receive stream so it is shown one bit before that frame starts.
// Assumes rx_data leads the counter position by two bit periods.
module t1rt_link
    import t1rt_pkg::*;
#(
    parameter int POS_W   = 8,
    parameter int PRE_POS = 191
) (
    input  logic             clk,
    input  logic             rst_n,
    input  fmt_e             fmt,
    input  logic [POS_W-1:0] pos,
    input  logic [FRM_W-1:0] nxt_frm,
    input  logic             rx_data,
    output logic             link_q
);
    // Load the link bit at the bit before the last when the next frame carries one.
    always_ff @(posedge clk) begin
        if (!rst_n)
            link_q <= 1'b0;
        else if (pos == POS_W'(PRE_POS) && link_frame(fmt, nxt_frm))
            link_q <= rx_data;
    end

endmodule

// File: rtl/t1rt_decode.sv
`timescale 1ns/1ps
// t1rt_decode: combinational decode of the counters into the sync pulses and
// the shared clock/data pair. Assumes all inputs are registered state.
module t1rt_decode
    import t1rt_pkg::*;
#(
    parameter int CHANNELS = 24,
    parameter int CH_BITS  = 8,
    localparam int FRAME_BITS = 1 + CHANNELS * CH_BITS,
    localparam int POS_W  = $clog2(FRAME_BITS),
    localparam int CH_W   = $clog2(CHANNELS),
    localparam int SLOT_W = $clog2(CH_BITS)
) (
    input  fmt_e              fmt,
    input  logic              active,
    input  logic              link_sel,
    input  logic              dbl_sig_en,
    input  logic [CHANNELS-1:0] chan_mask,
    input  logic [POS_W-1:0]  pos,
    input  logic [CH_W-1:0]   chan,
    input  logic [SLOT_W-1:0] slot,
    input  logic [FRM_W-1:0]  frm,
    input  logic              link_q,
    output logic              frame_sync,
    output logic              mframe_sync,
    output logic              aux_clk,
    output logic              aux_dat
);
    logic [CHANNELS-1:0] hit;
    logic is_fbit, ch_clk, ch_blk, lk_clk;

    // One hit term per channel: this channel is live and its mask bit is set.
    for (genvar i = 0; i < CHANNELS; i++) begin : g_mask
        assign hit[i] = (chan == CH_W'(i)) && chan_mask[i];
    end

    // Strobe decode, output select and alignment gating.
    always_comb begin
        is_fbit     = (pos == '0);
        ch_clk      = !is_fbit && (slot == SLOT_W'(CH_BITS - 1));
        ch_blk      = !is_fbit && (|hit);
        lk_clk      = is_fbit && link_frame(fmt, frm);
        frame_sync  = active && (is_fbit ||
                      (pos == POS_W'(1) && dbl_sig_en && sig_frame(frm)));
        mframe_sync = active && is_fbit && (frm == '0);
        aux_clk     = active && (link_sel ? lk_clk : ch_clk);
        aux_dat     = active && (link_sel ? link_q : ch_blk);
    end

endmodule

// File: rtl/t1_rx_timing.sv
`timescale 1ns/1ps
// t1_rx_timing: T1 receive timing pulse generator. One counter set drives
// frame sync, multiframe sync and a shared clock/data pair.
// Assumes the upstream framer has found alignment and supplies frame_start
// in the last bit time of each frame it wants to (re)align.
module t1_rx_timing
    import t1rt_pkg::*;
#(
    parameter int CHANNELS = 24,
    parameter int CH_BITS  = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [1:0]          fmt,
    input  logic                link_sel,
    input  logic                dbl_sig_en,
    input  logic [CHANNELS-1:0] chan_mask,
    input  logic                aligned,
    input  logic                frame_start,
    input  logic                mf_start,
    input  logic                rx_data,
    output logic                frame_sync,
    output logic                mframe_sync,
    output logic                aux_clk,
    output logic                aux_dat
);
    localparam int FRAME_BITS = 1 + CHANNELS * CH_BITS;
    localparam int POS_W  = $clog2(FRAME_BITS);
    localparam int CH_W   = $clog2(CHANNELS);
    localparam int SLOT_W = $clog2(CH_BITS);

    fmt_e              fmt_s;
    logic [POS_W-1:0]  pos;
    logic [CH_W-1:0]   chan;
    logic [SLOT_W-1:0] slot;
    logic [FRM_W-1:0]  frm, nxt_frm;
    logic              run, link_q;

    assign fmt_s = fmt_e'(fmt);

    t1rt_count #(.CHANNELS(CHANNELS), .CH_BITS(CH_BITS)) u_count (
        .clk(clk), .rst_n(rst_n), .fmt(fmt_s), .aligned(aligned),
        .frame_start(frame_start), .mf_start(mf_start),
        .pos(pos), .chan(chan), .slot(slot), .frm(frm),
        .nxt_frm(nxt_frm), .run(run)
    );

    t1rt_link #(.POS_W(POS_W), .PRE_POS(FRAME_BITS - 2)) u_link (
        .clk(clk), .rst_n(rst_n), .fmt(fmt_s), .pos(pos),
        .nxt_frm(nxt_frm), .rx_data(rx_data), .link_q(link_q)
    );

    t1rt_decode #(.CHANNELS(CHANNELS), .CH_BITS(CH_BITS)) u_decode (
        .fmt(fmt_s), .active(aligned && run), .link_sel(link_sel),
        .dbl_sig_en(dbl_sig_en), .chan_mask(chan_mask),
        .pos(pos), .chan(chan), .slot(slot), .frm(frm), .link_q(link_q),
        .frame_sync(frame_sync), .mframe_sync(mframe_sync),
        .aux_clk(aux_clk), .aux_dat(aux_dat)
    );

endmodule

// File: rtl/t1_rx_timing_chk.sv
`timescale 1ns/1ps
// t1_rx_timing_chk: port-level properties of the T1 receive timing block.
module t1_rx_timing_chk (
    input logic clk,
    input logic rst_n,
    input logic link_sel,
    input logic dbl_sig_en,
    input logic aligned,
    input logic frame_sync,
    input logic mframe_sync,
    input logic aux_clk,
    input logic aux_dat
);
    AST_QUIET_UNALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        !aligned |-> !(frame_sync || mframe_sync || aux_clk || aux_dat)); // R9

    AST_FSYNC_NO_TRIPLE: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_sync && $past(frame_sync)) |=> !frame_sync); // R4

    AST_FSYNC_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_sync && !dbl_sig_en) |=> !frame_sync); // R4

    AST_MSYNC_IN_FSYNC: assert property (@(posedge clk) disable iff (!rst_n)
        mframe_sync |-> frame_sync); // R5

    AST_MSYNC_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        mframe_sync |=> !mframe_sync); // R5

    AST_CHCLK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (!link_sel && aux_clk) |=> (!aux_clk || link_sel)); // R2

    AST_LCLK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (link_sel && aux_clk) |=> (!aux_clk || !link_sel)); // R6

endmodule

bind t1_rx_timing t1_rx_timing_chk u_chk (
    .clk(clk), .rst_n(rst_n), .link_sel(link_sel), .dbl_sig_en(dbl_sig_en),
    .aligned(aligned), .frame_sync(frame_sync), .mframe_sync(mframe_sync),
    .aux_clk(aux_clk), .aux_dat(aux_dat)
);

// File: tb/t1_rx_timing_tb.sv
`timescale 1ns/1ps
// Directed bench: a bench-side frame model from the requirements, one task per scenario.
module t1_rx_timing_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0]  fmt = 2'b00;
    logic        link_sel = 1'b0, dbl_sig_en = 1'b0, aligned = 1'b0;
    logic        frame_start = 1'b0, mf_start = 1'b0, rx_data = 1'b0;
    logic [23:0] chan_mask = '0;
    logic        frame_sync, mframe_sync, aux_clk, aux_dat;

    int checks = 0, fails = 0;
    int pos = 0, frm = 0, g = 0;
    bit synced = 0, cnt_valid = 0, link_known = 0, exp_link = 0;

    always #10 clk = ~clk;

    t1_rx_timing u_dut (
        .clk(clk), .rst_n(rst_n), .fmt(fmt), .link_sel(link_sel),
        .dbl_sig_en(dbl_sig_en), .chan_mask(chan_mask), .aligned(aligned),
        .frame_start(frame_start), .mf_start(mf_start), .rx_data(rx_data),
        .frame_sync(frame_sync), .mframe_sync(mframe_sync),
        .aux_clk(aux_clk), .aux_dat(aux_dat)
    );

    task automatic chk(string req, string what, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual=%0b expected=%0b (pos=%0d frame=%0d)",
                     req, what, act, exp, pos, frm + 1);
        end
    endtask

    function automatic int mf_len(logic [1:0] m);
        return (m == 2'b00) ? 12 : 24;
    endfunction

    function automatic bit is_link(logic [1:0] m, int f);
        int n = f + 1;
        if (m == 2'b00) return (n % 2) == 0;
        if (m == 2'b10) return (n % 4) == 1;
        return (n % 2) == 1;
    endfunction

    function automatic bit fbit(int k);
        logic [31:0] v = k;
        return v[1] ^ v[2] ^ v[4];
    endfunction

    // One bit time: drive inputs, check outputs mid-cycle, advance the model.
    task automatic step(input bit fs, input bit mf);
        int nf;
        bit act;
        @(negedge clk);
        frame_start = fs;
        mf_start    = mf;
        rx_data     = (pos == 191) ? fbit(g + 1) : bit'(pos % 2);
        nf = (frm + 1 >= mf_len(fmt)) ? 0 : frm + 1;
        if (cnt_valid && pos == 192 && is_link(fmt, nf)) begin
            exp_link   = fbit(g + 1);
            link_known = 1;
        end
        #1;
        act = aligned && synced;
        if (!act) begin
            chk("R9", "frame_sync quiet", frame_sync, 1'b0);
            chk("R9", "mframe_sync quiet", mframe_sync, 1'b0);
            chk("R9", "aux_clk quiet", aux_clk, 1'b0);
            chk("R9", "aux_dat quiet", aux_dat, 1'b0);
        end else begin
            chk("R4 R1", "frame_sync", frame_sync,
                pos == 0 || (pos == 1 && dbl_sig_en && ((frm + 1) % 6) == 0));
            chk("R5 R1", "mframe_sync", mframe_sync, pos == 0 && frm == 0);
            if (link_sel) begin
                chk("R6 R8", "link clock", aux_clk, pos == 0 && is_link(fmt, frm));
                if (link_known) chk("R7 R8", "link data", aux_dat, exp_link);
            end else begin
                chk("R2 R8", "channel clock", aux_clk, pos != 0 && (pos % 8) == 0);
                chk("R3 R8", "channel block", aux_dat,
                    pos != 0 && chan_mask[(pos - 1) / 8]);
            end
        end
        @(posedge clk);
        if (!aligned) synced = 0;
        else if (fs)  synced = 1;
        if (fs) cnt_valid = 1;
        if (fs || pos == 192) begin
            pos = 0;
            frm = (fs && mf) ? 0 : nf;
            g++;
        end else begin
            pos++;
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) begin
            @(negedge clk);
            chk("R10", "frame_sync in reset", frame_sync, 1'b0);
            chk("R10", "mframe_sync in reset", mframe_sync, 1'b0);
            chk("R10", "aux_clk in reset", aux_clk, 1'b0);
            chk("R10", "aux_dat in reset", aux_dat, 1'b0);
        end
        @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10", "outputs after reset", frame_sync | mframe_sync | aux_clk | aux_dat, 1'b0);
        @(posedge clk);
    endtask

    // Scenario: configure while unaligned, align, start, run frames with optional
    // realign (rs_frame/rs_pos/rs_mf), frame_start every frame, or a dropout.
    task automatic t_scenario(input logic [1:0] m, input bit sel, input bit dbl,
                              input logic [23:0] mk, input int nframes,
                              input int rs_frame, input int rs_pos, input bit rs_mf,
                              input bit every_fs, input int drop_frame);
        int g0;
        bit rs_done = 0;
        aligned = 1'b0; fmt = m; link_sel = sel; dbl_sig_en = dbl; chan_mask = mk;
        cnt_valid = 0; link_known = 0; synced = 0; pos = 100; frm = 0;
        repeat (3) step(0, 0);                     // R9: unaligned, outputs low
        aligned = 1'b1;
        pos = 185;
        while (pos != 192) step(0, 0);             // R9: aligned but no frame_start
        step(1, 1);                                // R1: start at frame 1
        g0 = g;
        while (g - g0 < nframes) begin
            if (!rs_done && g - g0 == rs_frame && pos == rs_pos) begin
                rs_done = 1;
                step(1, rs_mf);                    // R1: realign mid-stream
            end else if (g - g0 == drop_frame && pos == 60) begin
                aligned = 1'b0;                    // R9: dropout
                repeat (15) step(0, 0);
                aligned = 1'b1;
            end else begin
                step(every_fs && pos == 192, 0);
            end
        end
    endtask

    initial begin
        t_reset();
        t_scenario(2'b00, 0, 0, 24'hA5_0F3C, 26, -1, 0, 0, 0, -1);
        t_scenario(2'b01, 0, 1, 24'h80_0001, 30, 7, 100, 0, 0, -1);
        t_scenario(2'b01, 0, 1, 24'hFF_FFFF, 8, 3, 192, 1, 0, -1);
        t_scenario(2'b01, 1, 1, 24'h00_0000, 50, -1, 0, 0, 0, -1);
        t_scenario(2'b00, 1, 1, 24'h12_3456, 26, -1, 0, 0, 0, -1);
        t_scenario(2'b10, 1, 0, 24'h00_0000, 50, 10, 192, 1, 0, -1);
        t_scenario(2'b11, 1, 1, 24'h00_0000, 26, -1, 0, 0, 0, -1);
        t_scenario(2'b01, 0, 0, 24'h5A_5A5A, 6, -1, 0, 0, 1, 2);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #4000000;
        fails++;
        $display("FAIL R1 watchdog: actual=timeout expected=completion");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule